// File: doc/BRIEF.md
# Per-Branch Local History Table

This block stores one short history of branch outcomes for each entry of a directly indexed table. It is the first level of a two-level branch predictor. Several lookup ports read in parallel: each presents an entry index and gets that entry's stored outcome history back in the same cycle. The predictor's second level uses that history to choose a pattern counter.

Several resolution ports write in parallel. When a branch resolves, its port sends the entry index, the history value that was read when the branch was predicted, and the actual outcome. The entry then takes that carried history shifted up by one place, with the outcome entered at the bottom. The value currently held in the table is not used. Sending a carried history of zero with a not-taken outcome therefore sets an entry to zero, so any entry can be cleared through the normal write path.

Top module: `bhist_table`

## Requirements
- R1: Each of the N_PRED lookup ports drives, on its `pred_hist` slice, the history stored in the entry selected by its `pred_addr` slice. The output follows the address combinationally, within the same cycle. Port p uses bits [p*AW +: AW] of the address and bits [p*HIST_W +: HIST_W] of the history.
- R2: Every `pred_ack` bit and every `cmp_ack` bit is high in every cycle, so every valid request is accepted at the clock edge where it is presented.
- R3: A completion on port c with `cmp_vld[c]` high sets the addressed entry at that clock edge. The new value is the carried history shifted left by one, truncated to HIST_W bits, with the `cmp_dir` bit in bit 0 (1 = taken).
- R4: A lookup in the cycle after a completion returns the new value. A lookup of the same entry in the same cycle as the completion returns the previous value, because there is no forwarding.
- R5: A completion with carried history 0 and direction 0 leaves the addressed entry at 0, whatever it held before.
- R6: If several completion ports address the same entry in one cycle, the value from the highest-numbered of those ports is stored.
- R7: Completions on different ports to different entries in the same cycle all take effect at that edge.
- R8: While `rst_n` is low, every entry is zero and every lookup returns 0. After release, every entry reads 0 until it is written.
- R9: An address at or above ENTRIES writes nothing on a completion port and reads 0 on a lookup port. The in-range entries are left unchanged.
- R10: A completion port with `cmp_vld` low changes no entry, whatever its address, history and direction inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all entries |
| pred_vld | input | N_PRED | Lookup request valid, one bit per port |
| pred_addr | input | N_PRED*AW | Lookup entry index, AW bits per port |
| pred_ack | output | N_PRED | Lookup accepted, one bit per port |
| pred_hist | output | N_PRED*HIST_W | Stored history of the selected entry |
| cmp_vld | input | N_CMP | Completion valid, one bit per port |
| cmp_addr | input | N_CMP*AW | Completion entry index |
| cmp_hist_old | input | N_CMP*HIST_W | History read when the branch was predicted |
| cmp_dir | input | N_CMP | Resolved outcome, 1 = taken |
| cmp_ack | output | N_CMP | Completion accepted, one bit per port |

## Verification
The bench builds the table with 12 entries of 5-bit history, 3 lookup ports and 3 completion ports. With 12 entries the 4-bit index can take the values 12 to 15, so the dropped writes and zero reads of R9 can be exercised. A 5-bit history shows whether the top bit falls off correctly on the shift. Three completion ports allow a three-way collision on one entry, which tests priority beyond a simple pair, and three lookup ports allow a same-cycle read of an entry being written while the other ports read elsewhere.

// File: rtl/bhist_pkg.sv
package bhist_pkg;

  // True when an index selects an existing entry.
  function automatic logic idx_valid(input int unsigned idx, input int unsigned entries);
    return idx < entries;
  endfunction

endpackage

// File: rtl/bhist_shift.sv
module bhist_shift #(
  parameter int HIST_W = 4
) (
  input  logic [HIST_W-1:0] hist_old,
  input  logic              dir,
  output logic [HIST_W-1:0] hist_new
);

  generate
    if (HIST_W == 1) begin : g_single
      assign hist_new = dir;
    end else begin : g_multi
      assign hist_new = {hist_old[HIST_W-2:0], dir};
    end
  endgenerate

endmodule

// File: rtl/bhist_wr_sel.sv
module bhist_wr_sel #(
  parameter int N_CMP  = 2,
  parameter int AW     = 4,
  parameter int HIST_W = 4,
  parameter int IDX    = 0
) (
  input  logic [N_CMP-1:0]        cmp_vld,
  input  logic [N_CMP*AW-1:0]     cmp_addr,
  input  logic [N_CMP*HIST_W-1:0] cmp_hist_new,
  output logic                    we,
  output logic [HIST_W-1:0]       wdata
);

  localparam logic [AW-1:0] MY_IDX = AW'(IDX);

  // Later ports override earlier ones: highest index wins.
  always_comb begin
    we    = 1'b0;
    wdata = '0;
    for (int p = 0; p < N_CMP; p++) begin
      if (cmp_vld[p] && (cmp_addr[p*AW +: AW] == MY_IDX)) begin
        we    = 1'b1;
        wdata = cmp_hist_new[p*HIST_W +: HIST_W];
      end
    end
  end

endmodule

// File: rtl/bhist_rd_mux.sv
module bhist_rd_mux #(
  parameter int ENTRIES = 16,
  parameter int AW      = 4,
  parameter int HIST_W  = 4
) (
  input  logic [ENTRIES*HIST_W-1:0] tbl_flat,
  input  logic [AW-1:0]             addr,
  output logic [HIST_W-1:0]         hist
);

  import bhist_pkg::*;

  always_comb begin
    hist = '0;
    if (idx_valid(int'(addr), ENTRIES)) begin
      hist = tbl_flat[int'(addr)*HIST_W +: HIST_W];
    end
  end

endmodule

// File: rtl/bhist_table.sv
module bhist_table #(
  parameter int ENTRIES = 16,
  parameter int HIST_W  = 4,
  parameter int N_PRED  = 2,
  parameter int N_CMP   = 2,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PRED-1:0]        pred_vld,
  input  logic [N_PRED*AW-1:0]     pred_addr,
  output logic [N_PRED-1:0]        pred_ack,
  output logic [N_PRED*HIST_W-1:0] pred_hist,
  input  logic [N_CMP-1:0]         cmp_vld,
  input  logic [N_CMP*AW-1:0]      cmp_addr,
  input  logic [N_CMP*HIST_W-1:0]  cmp_hist_old,
  input  logic [N_CMP-1:0]         cmp_dir,
  output logic [N_CMP-1:0]         cmp_ack
);

  logic [N_CMP*HIST_W-1:0]   cmp_hist_new;
  logic [ENTRIES*HIST_W-1:0] tbl_flat;
  logic [ENTRIES-1:0]        ent_we;

  // Lookup valid only qualifies the caller's use of the data.
  logic                      unused_vld;
  assign unused_vld = ^pred_vld;

  assign pred_ack = '1;
  assign cmp_ack  = '1;

  // Shifted history per completion port.
  generate
    for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
      bhist_shift #(.HIST_W(HIST_W)) u_shift (
        .hist_old (cmp_hist_old[c*HIST_W +: HIST_W]),
        .dir      (cmp_dir[c]),
        .hist_new (cmp_hist_new[c*HIST_W +: HIST_W])
      );
    end
  endgenerate

  // Table entries: write select, next state, register.
  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [HIST_W-1:0] wdata;
      logic [HIST_W-1:0] hist_d;
      logic [HIST_W-1:0] hist_q;

      bhist_wr_sel #(
        .N_CMP  (N_CMP),
        .AW     (AW),
        .HIST_W (HIST_W),
        .IDX    (e)
      ) u_sel (
        .cmp_vld      (cmp_vld),
        .cmp_addr     (cmp_addr),
        .cmp_hist_new (cmp_hist_new),
        .we           (ent_we[e]),
        .wdata        (wdata)
      );

      always_comb begin
        hist_d = hist_q;
        if (ent_we[e]) hist_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= '0;
        end else if (ent_we[e]) begin
          hist_q <= hist_d;
        end
      end

      assign tbl_flat[e*HIST_W +: HIST_W] = hist_q;
    end
  endgenerate

  // Lookup ports.
  generate
    for (genvar p = 0; p < N_PRED; p++) begin : g_pred
      bhist_rd_mux #(
        .ENTRIES (ENTRIES),
        .AW      (AW),
        .HIST_W  (HIST_W)
      ) u_rd (
        .tbl_flat (tbl_flat),
        .addr     (pred_addr[p*AW +: AW]),
        .hist     (pred_hist[p*HIST_W +: HIST_W])
      );
    end
  endgenerate

endmodule

// File: rtl/bhist_table_chk.sv
module bhist_table_chk #(
  parameter int ENTRIES = 16,
  parameter int HIST_W  = 4,
  parameter int N_PRED  = 2,
  parameter int N_CMP   = 2,
  parameter int AW      = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_PRED*AW-1:0]     pred_addr,
  input logic [N_PRED*HIST_W-1:0] pred_hist,
  input logic [N_CMP-1:0]         cmp_vld,
  input logic [N_CMP*AW-1:0]      cmp_addr,
  input logic [N_CMP*HIST_W-1:0]  cmp_hist_old,
  input logic [N_CMP-1:0]         cmp_dir
);

  logic [AW-1:0]     top_addr;
  logic [HIST_W-1:0] top_old;
  logic [HIST_W-1:0] top_exp;
  logic [AW-1:0]     rd0_addr;
  logic [HIST_W-1:0] rd0_hist;

  assign top_addr = cmp_addr[(N_CMP-1)*AW +: AW];
  assign top_old  = cmp_hist_old[(N_CMP-1)*HIST_W +: HIST_W];
  assign top_exp  = HIST_W'(top_old << 1) | HIST_W'(cmp_dir[N_CMP-1]);
  assign rd0_addr = pred_addr[0 +: AW];
  assign rd0_hist = pred_hist[0 +: HIST_W];

  // R3 / R6: the highest completion port always lands its shifted value.
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld[N_CMP-1] && (int'(top_addr) < ENTRIES)) |=>
      ((rd0_addr != $past(top_addr)) || (rd0_hist == $past(top_exp))));

  // R10: with no completion, an unchanged lookup address gives an unchanged result.
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld == '0) |=>
      ((rd0_addr != $past(rd0_addr)) || (rd0_hist == $past(rd0_hist))));

  // R8 and R9: zero during reset and for missing entries.
  always @(negedge clk) begin
    for (int p = 0; p < N_PRED; p++) begin
      if (!rst_n) begin
        p_reset_zero_r8: assert (pred_hist[p*HIST_W +: HIST_W] == '0);
      end else if (int'(pred_addr[p*AW +: AW]) >= ENTRIES) begin
        p_oob_zero_r9: assert (pred_hist[p*HIST_W +: HIST_W] == '0);
      end
    end
  end

endmodule

bind bhist_table bhist_table_chk #(
  .ENTRIES (ENTRIES),
  .HIST_W  (HIST_W),
  .N_PRED  (N_PRED),
  .N_CMP   (N_CMP),
  .AW      (AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pred_addr    (pred_addr),
  .pred_hist    (pred_hist),
  .cmp_vld      (cmp_vld),
  .cmp_addr     (cmp_addr),
  .cmp_hist_old (cmp_hist_old),
  .cmp_dir      (cmp_dir)
);

// File: tb/bhist_table_tb.sv
`timescale 1ns/1ps
module bhist_table_tb_top;

  localparam int ENTRIES = 12;
  localparam int HW      = 5;
  localparam int NP      = 3;
  localparam int NC      = 3;
  localparam int AW      = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     pred_vld;
  logic [NP*AW-1:0]  pred_addr;
  logic [NP-1:0]     pred_ack;
  logic [NP*HW-1:0]  pred_hist;
  logic [NC-1:0]     cmp_vld;
  logic [NC*AW-1:0]  cmp_addr;
  logic [NC*HW-1:0]  cmp_hist_old;
  logic [NC-1:0]     cmp_dir;
  logic [NC-1:0]     cmp_ack;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bhist_table #(
    .ENTRIES (ENTRIES),
    .HIST_W  (HW),
    .N_PRED  (NP),
    .N_CMP   (NC)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pred_vld     (pred_vld),
    .pred_addr    (pred_addr),
    .pred_ack     (pred_ack),
    .pred_hist    (pred_hist),
    .cmp_vld      (cmp_vld),
    .cmp_addr     (cmp_addr),
    .cmp_hist_old (cmp_hist_old),
    .cmp_dir      (cmp_dir),
    .cmp_ack      (cmp_ack)
  );

  typedef struct {
    int          port;
    logic [HW-1:0] exp;
    string       tag;
  } item_t;

  item_t         sb_q[$];
  logic [HW-1:0] model [ENTRIES];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: request a lookup, expectation from the model as of the last edge.
  task automatic rd(input int p, input int a, input string tag);
    item_t it;
    pred_addr[p*AW +: AW] = AW'(a);
    pred_vld[p]           = 1'b1;
    it.port = p;
    it.exp  = (a < ENTRIES) ? model[a] : '0;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input int c, input int a, input int old, input bit dir);
    cmp_vld[c]                  = 1'b1;
    cmp_addr[c*AW +: AW]        = AW'(a);
    cmp_hist_old[c*HW +: HW]    = HW'(old);
    cmp_dir[c]                  = dir;
  endtask

  // Advance one edge and apply accepted completions to the model in port order.
  task automatic tick();
    @(posedge clk);
    for (int c = 0; c < NC; c++) begin
      if (cmp_vld[c] && (int'(cmp_addr[c*AW +: AW]) < ENTRIES))
        model[int'(cmp_addr[c*AW +: AW])] =
          HW'(cmp_hist_old[c*HW +: HW] << 1) | HW'(cmp_dir[c]);
    end
    #1;
    cmp_vld  = '0;
    pred_vld = '0;
  endtask

  // Monitor: compare lookup results away from the active edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(pred_hist[it.port*HW +: HW] == it.exp, it.tag,
            int'(pred_hist[it.port*HW +: HW]), int'(it.exp));
    end
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int e = 0; e < ENTRIES; e++) model[e] = '0;
    rst_n        = 1'b0;
    pred_vld     = '0;
    pred_addr    = '0;
    cmp_vld      = '0;
    cmp_addr     = '0;
    cmp_hist_old = '0;
    cmp_dir      = '0;

    // R8: zero while in reset.
    pred_addr = {AW'(2), AW'(7), AW'(11)};
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      check(pred_hist[p*HW +: HW] == '0, "R8 in reset", int'(pred_hist[p*HW +: HW]), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R8: every entry reads zero after release.
    for (int a = 0; a < ENTRIES; a += NP) begin
      for (int p = 0; p < NP; p++) if (a + p < ENTRIES) rd(p, a + p, "R8 after reset");
      tick();
    end

    // R2: acknowledges high.
    @(negedge clk);
    check((&pred_ack) && (&cmp_ack), "R2 ack", int'({pred_ack, cmp_ack}), (1 << (NP + NC)) - 1);
    @(posedge clk);
    #1;

    // R3/R4: write entry 3, same-cycle read sees old value.
    wr(0, 3, 5'b10110, 1'b1);
    rd(0, 3, "R4 no forwarding");
    tick();
    rd(0, 3, "R3 shifted value");
    rd(1, 3, "R4 read after update");
    tick();
    check(model[3] == 5'b01101, "R3 model value", int'(model[3]), 5'h0d);

    // R6: three-way collision on entry 5.
    wr(0, 5, 5'b00001, 1'b0);
    wr(1, 5, 5'b00010, 1'b1);
    wr(2, 5, 5'b11111, 1'b0);
    tick();
    rd(0, 5, "R6 highest port wins");
    tick();

    // R7: three ports, three entries.
    wr(0, 1, 5'b00111, 1'b1);
    wr(1, 2, 5'b10000, 1'b1);
    wr(2, 7, 5'b01010, 1'b0);
    tick();
    rd(0, 1, "R7 port0");
    rd(1, 2, "R7 port1");
    rd(2, 7, "R7 port2");
    tick();

    // R5: clear entry 5 with zero history, not taken.
    wr(1, 5, 0, 1'b0);
    tick();
    rd(2, 5, "R5 clear");
    tick();
    check(model[5] == '0, "R5 model cleared", int'(model[5]), 0);

    // R9: out-of-range writes and reads.
    wr(0, 13, 5'h1f, 1'b1);
    wr(1, 15, 5'h15, 1'b1);
    wr(2, 12, 5'h0a, 1'b1);
    tick();
    rd(0, 13, "R9 read oob");
    rd(1, 15, "R9 read oob");
    rd(2, 12, "R9 read oob");
    tick();
    for (int a = 0; a < ENTRIES; a += NP) begin
      for (int p = 0; p < NP; p++) if (a + p < ENTRIES) rd(p, a + p, "R9 entries intact");
      tick();
    end

    // R10: inputs present without valid.
    cmp_addr     = {AW'(3), AW'(1), AW'(7)};
    cmp_hist_old = {5'h1f, 5'h1f, 5'h1f};
    cmp_dir      = '1;
    tick();
    rd(0, 3, "R10 no write without valid");
    rd(1, 1, "R10 no write without valid");
    rd(2, 7, "R10 no write without valid");
    tick();

    // R1: mixed random traffic on all ports.
    for (int i = 0; i < 400; i++) begin
      for (int c = 0; c < NC; c++) begin
        if ($urandom_range(0, 1) == 1)
          wr(c, $urandom_range(0, 15), $urandom_range(0, 31), 1'($urandom_range(0, 1)));
      end
      for (int p = 0; p < NP; p++) rd(p, $urandom_range(0, 15), "R1 random lookup");
      tick();
    end

    @(posedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule